// File: doc/BRIEF.md
# Round-Robin Node Sampler with Dual-Port Capture Memory

This block watches a wide bundle of internal signals, cut into equal groups, and copies one group per sample slot into a small dual-port memory. A single scan index chooses which group the multiplexer passes on and also serves as the write address. Group g therefore always lands in memory word g, and each of its bits keeps a fixed position inside that word. A host can read any node's latest captured value through a read-only address and data port, without knowing where the sweep currently is.

A rate divider sets the sampling pace: with a divide value D, one group is captured every D+1 enabled cycles. The enable input freezes the whole sweep, both the divider phase and the scan index. A one-cycle flag marks the end of each pass over all groups, after which every memory word holds valid data.

Top module: `scan_logger`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the scan index and divider phase are 0 and `sweep_done_o` is low. Memory contents are undefined until the first sweep completes.
- R2: Group g is bits `[g*8 +: 8]` of `node_bus_i`. It is written to memory word g, and its bit b appears as bit b of `rd_data_o` when address g is read.
- R3: With `scan_en_i` high and divide value D on `rate_div_i`, one group is written every D+1 cycles. A full sweep of all 8 groups takes 8*(D+1) enabled cycles.
- R4: With `scan_en_i` low, the divider phase and the scan index hold and no memory word is written. The sweep resumes from the same point when the enable returns, so a pause of P cycles lengthens the current sweep by exactly P cycles.
- R5: After group 7 is written, the scan index wraps to 0. `sweep_done_o` is high for exactly one cycle, the cycle after the write of group 7.
- R6: The read port has no write path. `rd_data_o` presents the word at the `rd_addr_i` sampled on a rising edge from that edge onwards, which is one cycle of latency. A read of the word being written in the same cycle returns the old content.
- R7: After reset, once `scan_en_i` is raised with D = 0, the first `sweep_done_o` pulse follows the 8th rising edge with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en_i | input | 1 | Sweep enable; low freezes sampling |
| rate_div_i | input | 8 | Divide value D; one sample per D+1 enabled cycles |
| node_bus_i | input | 64 | Observed nodes, 8 groups of 8 bits, group g at bits g*8+7..g*8 |
| rd_addr_i | input | 3 | Host read address (group number) |
| rd_data_o | output | 8 | Registered read data, one cycle after the address |
| sweep_done_o | output | 1 | One-cycle pulse after group 7 has been written |

## Verification
The checker takes for granted that there are at least two groups, so that the end-of-sweep flag can never be high in two consecutive cycles. It also takes for granted that the divider phase only steps forward by one per enabled cycle. The stimulus changes the divide value only in the cycle a sweep-end pulse is seen, when the phase is 0, so the sweep length is always the full 8*(D+1). The node bus is changed only at pulse boundaries or while the enable is low, and memory is read back only after a complete sweep with stable inputs, so every expected word is fully determined.

// File: rtl/scan_logger_pkg.sv
package scan_logger_pkg;

    // Geometry of the observed node bundle
    localparam int SL_NUM_GROUPS = 8;
    localparam int SL_GROUP_W    = 8;
    localparam int SL_RATE_W     = 8;

    // Derived widths
    localparam int SL_IDX_W = (SL_NUM_GROUPS > 1) ? $clog2(SL_NUM_GROUPS) : 1;
    localparam int SL_BUS_W = SL_NUM_GROUPS * SL_GROUP_W;

    typedef logic [SL_IDX_W-1:0]   idx_t;
    typedef logic [SL_GROUP_W-1:0] word_t;
    typedef logic [SL_RATE_W-1:0]  rate_t;
    typedef logic [SL_BUS_W-1:0]   bus_t;

    localparam idx_t SL_LAST_IDX = idx_t'(SL_NUM_GROUPS - 1);

    // Write request from the sweep engine to the capture memory
    typedef struct packed {
        logic  en;
        idx_t  addr;
        word_t data;
    } wr_req_t;

    // Advance the scan index with wrap at the last group
    function automatic idx_t next_idx(input idx_t cur);
        if (cur == SL_LAST_IDX) begin
            return '0;
        end
        return cur + idx_t'(1);
    endfunction

endpackage

// File: rtl/scan_logger_pacer.sv
module scan_logger_pacer
    import scan_logger_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  rate_t rate,
    output logic  stb,
    output rate_t phase
);

    // A slot fires once the phase has reached the divide value; using >=
    // means a lowered divide value takes effect at the next enabled cycle.
    always_comb begin
        stb = en && (phase >= rate);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (en) begin
            if (stb) begin
                phase <= '0;
            end else begin
                phase <= phase + rate_t'(1);
            end
        end
    end

endmodule

// File: rtl/scan_logger_sweep.sv
module scan_logger_sweep
    import scan_logger_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stb,
    input  bus_t    nodes,
    output idx_t    idx,
    output wr_req_t wr,
    output logic    done
);

    // Split the node bundle into its groups
    word_t grp [SL_NUM_GROUPS];

    for (genvar g = 0; g < SL_NUM_GROUPS; g++) begin : g_slice
        assign grp[g] = nodes[g*SL_GROUP_W +: SL_GROUP_W];
    end

    // The same index picks the group and addresses the memory
    always_comb begin
        wr.en   = stb;
        wr.addr = idx;
        wr.data = grp[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= stb && (idx == SL_LAST_IDX);
            if (stb) begin
                idx <= next_idx(idx);
            end
        end
    end

endmodule

// File: rtl/scan_logger_dpram.sv
module scan_logger_dpram
    import scan_logger_pkg::*;
(
    input  logic    clk,
    input  wr_req_t wr,
    input  idx_t    rd_addr,
    output word_t   rd_data
);

    word_t mem [SL_NUM_GROUPS];

    // Port A: write only, fed by the sweep engine
    always_ff @(posedge clk) begin
        if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    // Port B: read only, registered, old data on a same-cycle collision
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/scan_logger.sv
module scan_logger
    import scan_logger_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scan_en_i,
    input  logic [SL_RATE_W-1:0]          rate_div_i,
    input  logic [SL_BUS_W-1:0]           node_bus_i,
    input  logic [SL_IDX_W-1:0]           rd_addr_i,
    output logic [SL_GROUP_W-1:0]         rd_data_o,
    output logic                          sweep_done_o
);

    logic    samp_stb;
    rate_t   pace_phase;
    idx_t    scan_idx;
    wr_req_t wr_req;

    scan_logger_pacer u_pacer (
        .clk   (clk),
        .rst   (rst),
        .en    (scan_en_i),
        .rate  (rate_div_i),
        .stb   (samp_stb),
        .phase (pace_phase)
    );

    scan_logger_sweep u_sweep (
        .clk   (clk),
        .rst   (rst),
        .stb   (samp_stb),
        .nodes (node_bus_i),
        .idx   (scan_idx),
        .wr    (wr_req),
        .done  (sweep_done_o)
    );

    scan_logger_dpram u_mem (
        .clk     (clk),
        .wr      (wr_req),
        .rd_addr (rd_addr_i),
        .rd_data (rd_data_o)
    );

endmodule

// File: rtl/scan_logger_chk.sv
module scan_logger_chk
    import scan_logger_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  scan_en,
    input logic  stb,
    input idx_t  idx,
    input rate_t phase,
    input logic  done
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (idx == '0 && phase == '0 && !done));

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> idx == $past(idx));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> phase == $past(phase));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && idx == SL_LAST_IDX) |=> (idx == '0 && done));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && idx != SL_LAST_IDX) |=> (idx == $past(idx) + 1'b1 && !done));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        stb |=> phase == '0);

    // R3
    phase_count_chk: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !stb) |=> phase == $past(phase) + 1'b1);

endmodule

bind scan_logger scan_logger_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scan_en (scan_en_i),
    .stb     (samp_stb),
    .idx     (scan_idx),
    .phase   (pace_phase),
    .done    (sweep_done_o)
);

// File: tb/sim_scan_logger.sv
`timescale 1ns/1ps
module sim_scan_logger;

    localparam int NG = 8;
    localparam int GW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_en_i = 1'b0;
    logic [7:0]    rate_div_i = '0;
    logic [63:0]   node_bus_i = '0;
    logic [2:0]    rd_addr_i = '0;
    logic [7:0]    rd_data_o;
    logic          sweep_done_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scan_logger u0 (
        .clk          (clk),
        .rst          (rst),
        .scan_en_i    (scan_en_i),
        .rate_div_i   (rate_div_i),
        .node_bus_i   (node_bus_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .sweep_done_o (sweep_done_o)
    );

    typedef struct {
        int         addr;
        logic [7:0] exp;
        string      req;
        int         stamp;
    } rd_item_t;

    rd_item_t sb_q[$];

    function automatic logic [7:0] pat(input logic [7:0] seed, input int g);
        return seed ^ 8'((g * 37) + 1);
    endfunction

    function automatic logic [63:0] mk_bus(input logic [7:0] seed);
        logic [63:0] b;
        for (int g = 0; g < NG; g++) b[g*GW +: GW] = pat(seed, g);
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: present a read address, queue the expected word
    task automatic rd(input int addr, input logic [7:0] exp, input string req);
        rd_item_t it;
        @(negedge clk);
        rd_addr_i = 3'(addr);
        it.addr = addr; it.exp = exp; it.req = req; it.stamp = cyc;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each read one edge after it was presented
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
            rd_item_t it;
            it = sb_q.pop_front();
            check(rd_data_o === it.exp, it.req, int'(rd_data_o), int'(it.exp));
        end
    end

    task automatic read_all(input logic [7:0] seed, input string req);
        for (int g = 0; g < NG; g++) rd(g, pat(seed, g), req);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Wait at negedges for the sweep-end pulse; returns the cycle stamp
    task automatic wait_done(output int at, input string req);
        at = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sweep_done_o) begin
                at = cyc;
                break;
            end
        end
        if (at < 0) check(1'b0, req, 0, 1);
    endtask

    initial begin
        int t0, t1, t2, plo, phi;
        node_bus_i = mk_bus(8'h11);
        repeat (4) @(negedge clk);
        check(sweep_done_o == 1'b0, "R1", int'(sweep_done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sweep_done_o == 1'b0, "R1", int'(sweep_done_o), 0);

        // Enable low after reset: no sweep may complete (R4)
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(sweep_done_o == 1'b0, "R4", int'(sweep_done_o), 0);
        end

        // First sweep at D = 0 (R7)
        scan_en_i = 1'b1;
        t0 = cyc;
        wait_done(t1, "R7");
        check(t1 - t0 == NG, "R7", t1 - t0, NG);
        @(negedge clk);
        check(sweep_done_o == 1'b0, "R5", int'(sweep_done_o), 0);
        read_all(8'h11, "R2");

        // Rate 0 sweep period (R3)
        wait_done(t1, "R3");
        wait_done(t2, "R3");
        check(t2 - t1 == NG, "R3", t2 - t1, NG);

        // Rate 3, new pattern, changed at a pulse boundary (phase is 0)
        rate_div_i = 8'd3;
        node_bus_i = mk_bus(8'hA5);
        wait_done(t1, "R3");
        check(t1 - t2 == NG * 4, "R3", t1 - t2, NG * 4);
        read_all(8'hA5, "R2");
        wait_done(t1, "R3");
        wait_done(t2, "R3");
        check(t2 - t1 == NG * 4, "R3", t2 - t1, NG * 4);

        // Pause mid-sweep with new node values (R4)
        repeat (5) @(negedge clk);
        scan_en_i = 1'b0;
        node_bus_i = mk_bus(8'h3C);
        plo = cyc;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(sweep_done_o == 1'b0, "R4", int'(sweep_done_o), 0);
        end
        read_all(8'hA5, "R4");
        @(negedge clk);
        scan_en_i = 1'b1;
        phi = cyc;
        wait_done(t1, "R4");
        check(t1 - t2 == NG * 4 + (phi - plo), "R4", t1 - t2, NG * 4 + (phi - plo));

        // Next sweep rewrites the same addresses after the wrap (R5)
        wait_done(t2, "R5");
        check(t2 - t1 == NG * 4, "R5", t2 - t1, NG * 4);
        read_all(8'h3C, "R5");

        // Read port keeps stable data while the sweep keeps writing (R6)
        node_bus_i = mk_bus(8'hF0);
        wait_done(t1, "R6");
        wait_done(t1, "R6");
        for (int g = NG - 1; g >= 0; g--) rd(g, pat(8'hF0, g), "R6");
        rd(2, pat(8'hF0, 2), "R6");
        rd(2, pat(8'hF0, 2), "R6");
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule